// File: doc/BRIEF.md
# Hot-Swap Power-Up Sequencer

This block is the control core of a hot-swap controller for a negative supply rail. It decides when a newly inserted board may draw power. The rail monitor, the load comparator and the gate driver stay outside the block. They reach it only as single-bit flags, and the block answers with enable levels and a small state code.

Power-up runs in order:

1. The lockout-OK input must stay high for one probe period.
2. The sequencer then drives a test current into the load for at most one probe period, to screen out a shorted load.
3. The test passes as soon as the load-voltage comparator trips. The gate charge stage then begins.
4. The gate charge stage runs until the gate driver reports completion or a fault.

A failed probe or a gate fault takes one of two paths, chosen by the mode pin:

- **Retry mode:** the block waits sixteen probe periods and then runs the probe again.
- **Latch-off mode:** the block holds a fault until lockout-OK has stayed low for a minimum clear interval.

All intervals are parameters counted in clock cycles. A fast simulation can therefore use small values.

Top module: `hsw_sequencer`

## Requirements
- R1: A synchronous active-low reset puts the block in idle. After reset, stateCode is 0 and probeEn, gateEn and faultOut are all low.
- R2: The block leaves idle only after uvloOk has been high on PROBE_CYC consecutive clock edges. It then enters the probe state, stateCode 1. A low uvloOk in idle restarts this count.
- R3: probeEn is high exactly while in the probe state, and never for more than PROBE_CYC consecutive cycles.
- R4: loadAbove high during the probe state ends the probe on the next edge. The block enters the gate state, stateCode 2, with gateEn high and probeEn low.
- R5: If PROBE_CYC probe cycles pass without loadAbove, the probe fails. probeEn drops and the block takes the fault path.
- R6: In retry mode (latchMode low), the fault path enters backoff, stateCode 4, with faultOut high and both enables low. After 16*PROBE_CYC cycles in backoff, the block re-enters the probe state.
- R7: In latch mode (latchMode high), the fault path enters the latched state, stateCode 5, with faultOut high. The block stays there for as long as uvloOk is high. It returns to idle only after uvloOk has been low on CLR_CYC consecutive edges, and a high uvloOk restarts that count.
- R8: gateDone in the gate state moves the block to the on state, stateCode 3. gateEn stays high there.
- R9: gateFault in the gate state takes the same fault path as a failed probe, chosen by latchMode.
- R10: A low uvloOk in any state other than the latched state returns the block to idle on the next edge, with both enables low.
- R11: probeEn and gateEn are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| uvloOk | input | 1 | Debounced undervoltage-lockout-OK |
| loadAbove | input | 1 | Load voltage above the probe threshold |
| gateDone | input | 1 | Gate charge cycle completed normally |
| gateFault | input | 1 | Fault detected during gate charging |
| latchMode | input | 1 | 1 = latch-off on fault, 0 = auto-retry |
| probeEn | output | 1 | Load-probe current enable |
| gateEn | output | 1 | Gate charge enable |
| faultOut | output | 1 | Fault indication (backoff or latched) |
| stateCode | output | 3 | Current state code: 0 idle, 1 probe, 2 gate, 3 on, 4 backoff, 5 latched |

## Verification
The bench breaks the lockout qualification one cycle early and then holds it to its exact length. A design with an off-by-one count would probe too soon, or it would fail to restart the count after a drop.

The bench lets the probe run to its final allowed cycle and to one cycle past it. A wrong window would fail a healthy load early or leave the probe current on too long.

The bench times the retry backoff to the exact cycle, and it interrupts the latch-clear interval with a brief high. A design that clears the latch on any low pulse, or that never clears it, shows up as a wrong state code. Gate faults are driven in both modes, to catch a design that sends them down a different path from a failed probe.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PROBE   = 3'd1,
    ST_GATE    = 3'd2,
    ST_ON      = 3'd3,
    ST_BACKOFF = 3'd4,
    ST_LATCH   = 3'd5
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctlStrb_t;

  // datapath -> control terminal-count flags
  typedef struct packed {
    logic hitProbe;
    logic hitBackoff;
    logic hitClr;
  } tmrFlags_t;

endpackage

// File: rtl/hsw_timer.sv
module hsw_timer
  import hsw_pkg::*;
#(
  parameter int PROBE_CYC  = 2200000,
  parameter int CLR_CYC    = 15000,
  parameter int RETRY_MULT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctlStrb_t  strb,
  output tmrFlags_t flags
);

  localparam int BACKOFF_CYC = RETRY_MULT * PROBE_CYC;
  localparam int MAX_CYC     = (BACKOFF_CYC > CLR_CYC) ? BACKOFF_CYC : CLR_CYC;
  localparam int CW          = $clog2(MAX_CYC + 1);

  localparam logic [CW-1:0] PROBE_LAST   = CW'(PROBE_CYC - 1);
  localparam logic [CW-1:0] BACKOFF_LAST = CW'(BACKOFF_CYC - 1);
  localparam logic [CW-1:0] CLR_LAST     = CW'(CLR_CYC - 1);

  logic [CW-1:0] cnt;

  // one shared interval counter; the control decides which limit matters
  always_ff @(posedge clk) begin
    if (!rstN || strb.cntClr) cnt <= '0;
    else if (strb.cntInc)     cnt <= cnt + 1'b1;
  end

  always_comb begin
    flags.hitProbe   = (cnt == PROBE_LAST);
    flags.hitBackoff = (cnt == BACKOFF_LAST);
    flags.hitClr     = (cnt == CLR_LAST);
  end

endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      uvloOk,
  input  logic      loadAbove,
  input  logic      gateDone,
  input  logic      gateFault,
  input  logic      latchMode,
  input  tmrFlags_t flags,
  output ctlStrb_t  strb,
  output logic      probeEn,
  output logic      gateEn,
  output logic      faultOut,
  output logic [2:0] stateCode
);

  seqState_t state, nxt;
  seqState_t failDest;

  assign failDest = latchMode ? ST_LATCH : ST_BACKOFF;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    strb.cntClr = 1'b1;
    strb.cntInc = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (uvloOk) begin
          if (flags.hitProbe) nxt = ST_PROBE;
          else begin strb.cntClr = 1'b0; strb.cntInc = 1'b1; end
        end
      end
      ST_PROBE: begin
        if (!uvloOk)             nxt = ST_IDLE;
        else if (loadAbove)      nxt = ST_GATE;
        else if (flags.hitProbe) nxt = failDest;
        else begin strb.cntClr = 1'b0; strb.cntInc = 1'b1; end
      end
      ST_GATE: begin
        if (!uvloOk)        nxt = ST_IDLE;
        else if (gateFault) nxt = failDest;
        else if (gateDone)  nxt = ST_ON;
      end
      ST_ON: begin
        if (!uvloOk) nxt = ST_IDLE;
      end
      ST_BACKOFF: begin
        if (!uvloOk)               nxt = ST_IDLE;
        else if (flags.hitBackoff) nxt = ST_PROBE;
        else begin strb.cntClr = 1'b0; strb.cntInc = 1'b1; end
      end
      ST_LATCH: begin
        if (!uvloOk) begin
          if (flags.hitClr) nxt = ST_IDLE;
          else begin strb.cntClr = 1'b0; strb.cntInc = 1'b1; end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    probeEn   = (state == ST_PROBE);
    gateEn    = (state == ST_GATE) || (state == ST_ON);
    faultOut  = (state == ST_BACKOFF) || (state == ST_LATCH);
    stateCode = state;
  end

endmodule

// File: rtl/hsw_sequencer.sv
module hsw_sequencer
  import hsw_pkg::*;
#(
  parameter int PROBE_CYC  = 2200000,
  parameter int CLR_CYC    = 15000,
  parameter int RETRY_MULT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvloOk,
  input  logic       loadAbove,
  input  logic       gateDone,
  input  logic       gateFault,
  input  logic       latchMode,
  output logic       probeEn,
  output logic       gateEn,
  output logic       faultOut,
  output logic [2:0] stateCode
);

  ctlStrb_t  strb;
  tmrFlags_t flags;

  hsw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .uvloOk    (uvloOk),
    .loadAbove (loadAbove),
    .gateDone  (gateDone),
    .gateFault (gateFault),
    .latchMode (latchMode),
    .flags     (flags),
    .strb      (strb),
    .probeEn   (probeEn),
    .gateEn    (gateEn),
    .faultOut  (faultOut),
    .stateCode (stateCode)
  );

  hsw_timer #(
    .PROBE_CYC  (PROBE_CYC),
    .CLR_CYC    (CLR_CYC),
    .RETRY_MULT (RETRY_MULT)
  ) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .flags (flags)
  );

endmodule

// File: rtl/hsw_sequencer_chk.sv
module hsw_sequencer_chk #(
  parameter int PROBE_CYC = 2200000
) (
  input logic       clk,
  input logic       rstN,
  input logic       uvloOk,
  input logic       loadAbove,
  input logic       gateDone,
  input logic       gateFault,
  input logic       latchMode,
  input logic       probeEn,
  input logic       gateEn,
  input logic       faultOut,
  input logic [2:0] stateCode
);

  int probeRun;

  always_ff @(posedge clk) begin
    if (!rstN)        probeRun <= 0;
    else if (probeEn) probeRun <= probeRun + 1;
    else              probeRun <= 0;
  end

  // R11
  enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(probeEn && gateEn));

  // R3
  probe_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeEn |-> (probeRun < PROBE_CYC));

  // R4
  probe_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd1 && uvloOk && loadAbove) |=> (stateCode == 3'd2 && gateEn && !probeEn));

  // R8
  gate_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd2 && uvloOk && !gateFault && gateDone) |=> (stateCode == 3'd3 && gateEn));

  // R9
  gate_fault_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd2 && uvloOk && gateFault && latchMode) |=> (stateCode == 3'd5));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd5 && uvloOk) |=> (stateCode == 3'd5 && faultOut));

  // R10
  lockout_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!uvloOk && stateCode != 3'd5) |=> (stateCode == 3'd0 && !probeEn && !gateEn));

endmodule

bind hsw_sequencer hsw_sequencer_chk #(.PROBE_CYC(PROBE_CYC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .uvloOk    (uvloOk),
  .loadAbove (loadAbove),
  .gateDone  (gateDone),
  .gateFault (gateFault),
  .latchMode (latchMode),
  .probeEn   (probeEn),
  .gateEn    (gateEn),
  .faultOut  (faultOut),
  .stateCode (stateCode)
);

// File: tb/sim_hsw_sequencer.sv
`timescale 1ns/1ps
module sim_hsw_sequencer;

  localparam int P    = 20;
  localparam int CLR  = 6;
  localparam int MULT = 16;

  logic clk = 1'b0;
  logic rstN, uvloOk, loadAbove, gateDone, gateFault, latchMode;
  logic probeEn, gateEn, faultOut;
  logic [2:0] stateCode;

  always #2.5 clk = ~clk;

  hsw_sequencer #(.PROBE_CYC(P), .CLR_CYC(CLR), .RETRY_MULT(MULT)) u0 (
    .clk(clk), .rstN(rstN), .uvloOk(uvloOk), .loadAbove(loadAbove),
    .gateDone(gateDone), .gateFault(gateFault), .latchMode(latchMode),
    .probeEn(probeEn), .gateEn(gateEn), .faultOut(faultOut), .stateCode(stateCode)
  );

  typedef struct {
    string      req;
    logic       p;
    logic       g;
    logic       f;
    logic [2:0] c;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // driver side: queue an expectation for the current sample point
  task automatic expect_out(input string req, input logic p, input logic g,
                            input logic f, input logic [2:0] c);
    exp_t e;
    e.req = req; e.p = p; e.g = g; e.f = f; e.c = c;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops and compares shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (probeEn !== e.p || gateEn !== e.g || faultOut !== e.f || stateCode !== e.c) begin
          errors++;
          $display("FAIL %s: got probe=%b gate=%b fault=%b code=%0d, expected probe=%b gate=%b fault=%b code=%0d",
                   e.req, probeEn, gateEn, faultOut, stateCode, e.p, e.g, e.f, e.c);
        end
        checks++;
        if (probeEn && gateEn) begin
          errors++;
          $display("FAIL R11: got probe=%b gate=%b, expected not both high", probeEn, gateEn);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; uvloOk = 1'b1; loadAbove = 1'b0; gateDone = 1'b0;
    gateFault = 1'b0; latchMode = 1'b0;
    step(3);
    expect_out("R1 reset", 0, 0, 0, 3'd0);
    uvloOk = 1'b0;
    step(1);
    rstN = 1'b1;

    // R2: interrupted qualification restarts
    uvloOk = 1'b1; step(P - 1);
    expect_out("R2 not yet qualified", 0, 0, 0, 3'd0);
    uvloOk = 1'b0; step(1);
    expect_out("R10 idle on drop", 0, 0, 0, 3'd0);
    uvloOk = 1'b1; step(P - 1);
    expect_out("R2 one edge short", 0, 0, 0, 3'd0);
    step(1);
    expect_out("R2 R3 probe entered", 1, 0, 0, 3'd1);

    // R4 probe pass, R8 gate done
    step(5); loadAbove = 1'b1; step(1);
    expect_out("R4 gate after pass", 0, 1, 0, 3'd2);
    loadAbove = 1'b0; step(3);
    expect_out("R4 gate holds", 0, 1, 0, 3'd2);
    gateDone = 1'b1; step(1);
    expect_out("R8 on state", 0, 1, 0, 3'd3);
    gateDone = 1'b0; step(4);
    expect_out("R8 on holds", 0, 1, 0, 3'd3);
    uvloOk = 1'b0; step(1);
    expect_out("R10 drop from on", 0, 0, 0, 3'd0);

    // R5 R6 timeout in retry mode
    latchMode = 1'b0; uvloOk = 1'b1; step(P);
    expect_out("R2 probe again", 1, 0, 0, 3'd1);
    step(P - 1);
    expect_out("R3 last probe cycle", 1, 0, 0, 3'd1);
    step(1);
    expect_out("R5 R6 backoff", 0, 0, 1, 3'd4);
    step(MULT * P - 1);
    expect_out("R6 backoff last cycle", 0, 0, 1, 3'd4);
    step(1);
    expect_out("R6 retry probe", 1, 0, 0, 3'd1);

    // R9 gate fault in retry mode
    loadAbove = 1'b1; step(1); loadAbove = 1'b0;
    expect_out("R4 gate", 0, 1, 0, 3'd2);
    gateFault = 1'b1; step(1); gateFault = 1'b0;
    expect_out("R9 retry backoff", 0, 0, 1, 3'd4);
    uvloOk = 1'b0; step(1);
    expect_out("R10 drop from backoff", 0, 0, 0, 3'd0);

    // R9 gate fault in latch mode, R7 clear interval
    latchMode = 1'b1; uvloOk = 1'b1; step(P);
    expect_out("R2 probe", 1, 0, 0, 3'd1);
    loadAbove = 1'b1; step(1); loadAbove = 1'b0;
    gateFault = 1'b1; step(1); gateFault = 1'b0;
    expect_out("R9 latched", 0, 0, 1, 3'd5);
    step(50);
    expect_out("R7 latched holds", 0, 0, 1, 3'd5);
    uvloOk = 1'b0; step(CLR - 1);
    expect_out("R7 low short of clear", 0, 0, 1, 3'd5);
    uvloOk = 1'b1; step(1);
    expect_out("R7 restart on high", 0, 0, 1, 3'd5);
    uvloOk = 1'b0; step(CLR - 1);
    expect_out("R7 still latched", 0, 0, 1, 3'd5);
    step(1);
    expect_out("R7 cleared to idle", 0, 0, 0, 3'd0);

    // R5 R7 probe timeout in latch mode
    uvloOk = 1'b1; step(P);
    expect_out("R2 probe", 1, 0, 0, 3'd1);
    step(P);
    expect_out("R5 R7 latched on timeout", 0, 0, 1, 3'd5);
    uvloOk = 1'b0; step(CLR);
    expect_out("R7 clear", 0, 0, 0, 3'd0);

    step(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule